// File: doc/BRIEF.md
# Register-to-Register ALU Operation Unit

This unit executes the single-cycle implied operations of an 8-bit accumulator processor that touch only the three data registers (A, X, Y) and the four condition flags (N, V, Z, C). The surrounding core presents the current register and flag values together with an operation code and a one-cycle execute strobe. One clock later the unit returns the complete updated register and flag set, per-register write enables and a done pulse.

Supported work covers copies between the index registers and exchanges of any register pair. It also covers AND, OR and XOR of A with an index register, and binary add or subtract with carry of an index register into A. Compares run in all six register directions, and there are two direct flag operations: force overflow high and invert carry. Arithmetic is binary only. No decimal-mode input exists, so decimal adjust can never take place here.

Top module: `regalu_unit`

## Requirements
- R1: While rst_n is low, done_o and all three write enables are 0, and every register and flag output is 0.
- R2: A high exec_i in cycle k gives done_o high in cycle k+1 with results from the inputs sampled at cycle k. In a cycle after exec_i was low, done_o and all write enables are 0.
- R3: Code 0 sets V to 1, and code 1 inverts C. Neither writes any register or changes any other flag.
- R4: Code 2 copies X into Y and code 3 copies Y into X. Only the destination is written, N and Z follow the copied value, and V and C are kept.
- R5: Code 4 swaps A and X, code 5 swaps A and Y and code 6 swaps X and Y. Both registers of the pair are written, N and Z follow the new A (codes 4, 5) or the new X (code 6), and V and C are kept.
- R6: Codes 7/8 put A AND X / A AND Y into A. Codes 9/10 do the same with OR, and codes 11/12 with XOR. N and Z follow the result, and V and C are kept.
- R7: Codes 13/14 put A+X+C / A+Y+C into A. C becomes the carry out of bit 7 and V becomes the signed overflow, with N and Z taken from the result.
- R8: Codes 15/16 put A-X-(1-C) / A-Y-(1-C) into A. C becomes 1 when no borrow occurred and V becomes the signed overflow, with N and Z taken from the result.
- R9: Codes 17..22 compare A:X, A:Y, X:A, X:Y, Y:A and Y:X (first minus second). No register is written. C = first >= second (unsigned), Z = first == second and N = bit 7 of the 8-bit difference, while V is kept.
- R10: Codes 23..31 write no register and leave all four flags at their input values, but done_o still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_i | input | 1 | Execute strobe, one cycle per operation |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Current A |
| x_i | input | 8 | Current X |
| y_i | input | 8 | Current Y |
| n_i | input | 1 | Current N flag |
| v_i | input | 1 | Current V flag |
| z_i | input | 1 | Current Z flag |
| c_i | input | 1 | Current C flag |
| done_o | output | 1 | Result valid pulse |
| a_we_o | output | 1 | A write enable |
| x_we_o | output | 1 | X write enable |
| y_we_o | output | 1 | Y write enable |
| a_o | output | 8 | New A (old value when not written) |
| x_o | output | 8 | New X (old value when not written) |
| y_o | output | 8 | New Y (old value when not written) |
| n_o | output | 1 | New N flag |
| v_o | output | 1 | New V flag |
| z_o | output | 1 | New Z flag |
| c_o | output | 1 | New C flag |

## Verification
The assertions assume that the core holds the register and flag inputs valid in every cycle in which exec_i is high. They compare outputs one cycle later against those sampled inputs and make no assumption about idle cycles. The bench drives every input for each operation on the falling edge and keeps it through the following rising edge. It mixes back-to-back strobes with idle gaps, so each result depends only on the cycle of its own strobe.

// File: rtl/regalu_unit.sv
module regalu_unit #(
  parameter int DW  = 8,
  parameter int OPW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exec_i,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  x_i,
  input  logic [DW-1:0]  y_i,
  input  logic           n_i,
  input  logic           v_i,
  input  logic           z_i,
  input  logic           c_i,
  output logic           done_o,
  output logic           a_we_o,
  output logic           x_we_o,
  output logic           y_we_o,
  output logic [DW-1:0]  a_o,
  output logic [DW-1:0]  x_o,
  output logic [DW-1:0]  y_o,
  output logic           n_o,
  output logic           v_o,
  output logic           z_o,
  output logic           c_o
);

  localparam logic [OPW-1:0] OP_SETV = OPW'(0);
  localparam logic [OPW-1:0] OP_CMC  = OPW'(1);
  localparam logic [OPW-1:0] OP_MVXY = OPW'(2);
  localparam logic [OPW-1:0] OP_MVYX = OPW'(3);
  localparam logic [OPW-1:0] OP_XAX  = OPW'(4);
  localparam logic [OPW-1:0] OP_XAY  = OPW'(5);
  localparam logic [OPW-1:0] OP_XXY  = OPW'(6);
  localparam logic [OPW-1:0] OP_ANDX = OPW'(7);
  localparam logic [OPW-1:0] OP_ANDY = OPW'(8);
  localparam logic [OPW-1:0] OP_ORX  = OPW'(9);
  localparam logic [OPW-1:0] OP_ORY  = OPW'(10);
  localparam logic [OPW-1:0] OP_XORX = OPW'(11);
  localparam logic [OPW-1:0] OP_XORY = OPW'(12);
  localparam logic [OPW-1:0] OP_ADDX = OPW'(13);
  localparam logic [OPW-1:0] OP_ADDY = OPW'(14);
  localparam logic [OPW-1:0] OP_SUBX = OPW'(15);
  localparam logic [OPW-1:0] OP_SUBY = OPW'(16);
  localparam logic [OPW-1:0] OP_CAX  = OPW'(17);
  localparam logic [OPW-1:0] OP_CAY  = OPW'(18);
  localparam logic [OPW-1:0] OP_CXA  = OPW'(19);
  localparam logic [OPW-1:0] OP_CXY  = OPW'(20);
  localparam logic [OPW-1:0] OP_CYA  = OPW'(21);
  localparam logic [OPW-1:0] OP_CYX  = OPW'(22);
  localparam int MSB = DW - 1;

  // second ALU operand: odd codes in 7..15 take X, even codes in 8..16 take Y
  logic [DW-1:0] opnd;
  logic          is_sub;
  logic [DW-1:0] addend;
  logic [DW:0]   sum;
  logic          ovf;

  assign opnd   = op_i[0] ? x_i : y_i;
  assign is_sub = (op_i == OP_SUBX) || (op_i == OP_SUBY);
  assign addend = is_sub ? ~opnd : opnd;
  assign sum    = {1'b0, a_i} + {1'b0, addend} + {{DW{1'b0}}, c_i};
  assign ovf    = (a_i[MSB] == addend[MSB]) && (sum[MSB] != a_i[MSB]);

  logic [DW-1:0] cmp_l, cmp_r;
  logic [DW:0]   diff;

  always_comb begin
    cmp_l = a_i;
    cmp_r = x_i;
    unique case (op_i)
      OP_CAY:  begin cmp_l = a_i; cmp_r = y_i; end
      OP_CXA:  begin cmp_l = x_i; cmp_r = a_i; end
      OP_CXY:  begin cmp_l = x_i; cmp_r = y_i; end
      OP_CYA:  begin cmp_l = y_i; cmp_r = a_i; end
      OP_CYX:  begin cmp_l = y_i; cmp_r = x_i; end
      default: begin cmp_l = a_i; cmp_r = x_i; end
    endcase
  end

  assign diff = {1'b0, cmp_l} - {1'b0, cmp_r};

  logic [DW-1:0] na, nx, ny, nzsrc;
  logic          nwa, nwx, nwy, nn, nv, nz, nc, upd_nz;

  always_comb begin
    na = a_i;  nx = x_i;  ny = y_i;
    nwa = 1'b0; nwx = 1'b0; nwy = 1'b0;
    nv = v_i;  nc = c_i;
    upd_nz = 1'b0;
    nzsrc  = a_i;
    unique case (op_i)
      OP_SETV: nv = 1'b1;
      OP_CMC:  nc = ~c_i;
      OP_MVXY: begin ny = x_i; nwy = 1'b1; nzsrc = x_i; upd_nz = 1'b1; end
      OP_MVYX: begin nx = y_i; nwx = 1'b1; nzsrc = y_i; upd_nz = 1'b1; end
      OP_XAX:  begin na = x_i; nx = a_i; nwa = 1'b1; nwx = 1'b1; nzsrc = x_i; upd_nz = 1'b1; end
      OP_XAY:  begin na = y_i; ny = a_i; nwa = 1'b1; nwy = 1'b1; nzsrc = y_i; upd_nz = 1'b1; end
      OP_XXY:  begin nx = y_i; ny = x_i; nwx = 1'b1; nwy = 1'b1; nzsrc = y_i; upd_nz = 1'b1; end
      OP_ANDX, OP_ANDY: begin na = a_i & opnd; nwa = 1'b1; nzsrc = a_i & opnd; upd_nz = 1'b1; end
      OP_ORX,  OP_ORY:  begin na = a_i | opnd; nwa = 1'b1; nzsrc = a_i | opnd; upd_nz = 1'b1; end
      OP_XORX, OP_XORY: begin na = a_i ^ opnd; nwa = 1'b1; nzsrc = a_i ^ opnd; upd_nz = 1'b1; end
      OP_ADDX, OP_ADDY, OP_SUBX, OP_SUBY: begin
        na = sum[MSB:0]; nwa = 1'b1; nzsrc = sum[MSB:0]; upd_nz = 1'b1;
        nc = sum[DW]; nv = ovf;
      end
      OP_CAX, OP_CAY, OP_CXA, OP_CXY, OP_CYA, OP_CYX: begin
        nzsrc = diff[MSB:0]; upd_nz = 1'b1; nc = ~diff[DW];
      end
      default: ;
    endcase
    nn = upd_nz ? nzsrc[MSB]          : n_i;
    nz = upd_nz ? (nzsrc == '0)       : z_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      a_we_o <= 1'b0; x_we_o <= 1'b0; y_we_o <= 1'b0;
      a_o <= '0; x_o <= '0; y_o <= '0;
      n_o <= 1'b0; v_o <= 1'b0; z_o <= 1'b0; c_o <= 1'b0;
    end else begin
      done_o <= exec_i;
      a_we_o <= exec_i & nwa;
      x_we_o <= exec_i & nwx;
      y_we_o <= exec_i & nwy;
      if (exec_i) begin
        a_o <= na; x_o <= nx; y_o <= ny;
        n_o <= nn; v_o <= nv; z_o <= nz; c_o <= nc;
      end
    end
  end

  p_done_after_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i |=> done_o);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> !done_o && !a_we_o && !x_we_o && !y_we_o);

  p_setv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && op_i == OP_SETV |=> v_o && c_o == $past(c_i) && n_o == $past(n_i)
      && z_o == $past(z_i) && !a_we_o && !x_we_o && !y_we_o);

  p_cmc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && op_i == OP_CMC |=> c_o != $past(c_i) && v_o == $past(v_i));

  p_swap_ax_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && op_i == OP_XAX |=> a_o == $past(x_i) && x_o == $past(a_i) && a_we_o && x_we_o);

  p_cmp_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && op_i >= OP_CAX && op_i <= OP_CYX |=> !a_we_o && !x_we_o && !y_we_o
      && v_o == $past(v_i));

  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && op_i > OP_CYX |=> done_o && !a_we_o && !x_we_o && !y_we_o
      && {n_o, v_o, z_o, c_o} == $past({n_i, v_i, z_i, c_i}));

endmodule

// File: tb/regalu_unit_bench.sv
module regalu_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exec_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] a_i = '0, x_i = '0, y_i = '0;
  logic n_i = 1'b0, v_i = 1'b0, z_i = 1'b0, c_i = 1'b0;
  logic done_o, a_we_o, x_we_o, y_we_o, n_o, v_o, z_o, c_o;
  logic [7:0] a_o, x_o, y_o;

  always #10 clk = ~clk;

  regalu_unit u_regalu_unit (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
    .a_i(a_i), .x_i(x_i), .y_i(y_i),
    .n_i(n_i), .v_i(v_i), .z_i(z_i), .c_i(c_i),
    .done_o(done_o), .a_we_o(a_we_o), .x_we_o(x_we_o), .y_we_o(y_we_o),
    .a_o(a_o), .x_o(x_o), .y_o(y_o),
    .n_o(n_o), .v_o(v_o), .z_o(z_o), .c_o(c_o)
  );

  typedef struct {
    logic [33:0] bits;   // a,x,y,aw,xw,yw,n,v,z,c
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit running = 0;

  function automatic string tag_of(int op);
    if (op <= 1) return "R3";
    if (op <= 3) return "R4";
    if (op <= 6) return "R5";
    if (op <= 12) return "R6";
    if (op <= 14) return "R7";
    if (op <= 16) return "R8";
    if (op <= 22) return "R9";
    return "R10";
  endfunction

  function automatic int sx(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic logic [33:0] model(int op, int a, int x, int y, int n, int v, int z, int c);
    int ra = a, rx = x, ry = y, aw = 0, xw = 0, yw = 0;
    int nn = n, vv = v, zz = z, cc = c;
    int b, r, s, f, t;
    bit setnz = 0;
    int nzv = 0;
    case (op)
      0: vv = 1;
      1: cc = 1 - c;
      2: begin ry = x; yw = 1; setnz = 1; nzv = ry; end
      3: begin rx = y; xw = 1; setnz = 1; nzv = rx; end
      4: begin ra = x; rx = a; aw = 1; xw = 1; setnz = 1; nzv = ra; end
      5: begin ra = y; ry = a; aw = 1; yw = 1; setnz = 1; nzv = ra; end
      6: begin rx = y; ry = x; xw = 1; yw = 1; setnz = 1; nzv = rx; end
      7, 8, 9, 10, 11, 12: begin
        b = (op % 2 == 1) ? x : y;
        if (op <= 8) r = a & b; else if (op <= 10) r = a | b; else r = a ^ b;
        ra = r; aw = 1; setnz = 1; nzv = r;
      end
      13, 14: begin
        b = (op == 13) ? x : y;
        s = a + b + c; ra = s % 256; cc = (s > 255) ? 1 : 0;
        t = sx(a) + sx(b) + c; vv = (t > 127 || t < -128) ? 1 : 0;
        aw = 1; setnz = 1; nzv = ra;
      end
      15, 16: begin
        b = (op == 15) ? x : y;
        s = a - b - (1 - c); cc = (s >= 0) ? 1 : 0; ra = (s + 512) % 256;
        t = sx(a) - sx(b) - (1 - c); vv = (t > 127 || t < -128) ? 1 : 0;
        aw = 1; setnz = 1; nzv = ra;
      end
      17, 18, 19, 20, 21, 22: begin
        case (op)
          17: begin f = a; s = x; end
          18: begin f = a; s = y; end
          19: begin f = x; s = a; end
          20: begin f = x; s = y; end
          21: begin f = y; s = a; end
          default: begin f = y; s = x; end
        endcase
        cc = (f >= s) ? 1 : 0;
        zz = (f == s) ? 1 : 0;
        nn = (((f - s + 256) % 256) >= 128) ? 1 : 0;
      end
      default: ;
    endcase
    if (setnz) begin
      nn = (nzv >= 128) ? 1 : 0;
      zz = (nzv == 0) ? 1 : 0;
    end
    return {8'(ra), 8'(rx), 8'(ry), 1'(aw), 1'(xw), 1'(yw), 1'(nn), 1'(vv), 1'(zz), 1'(cc)};
  endfunction

  task automatic issue(int op, int a, int x, int y, int fl);
    exp_t e;
    @(negedge clk);
    exec_i = 1'b1; op_i = 5'(op);
    a_i = 8'(a); x_i = 8'(x); y_i = 8'(y);
    {n_i, v_i, z_i, c_i} = 4'(fl);
    e.bits = model(op, a, x, y, fl / 8 % 2, fl / 4 % 2, fl / 2 % 2, fl % 2);
    e.req  = tag_of(op);
    q.push_back(e);
  endtask

  task automatic idle(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      exec_i = 1'b0;
      a_i = 8'hA5; x_i = 8'h3C; op_i = 5'd4;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (running) begin
      logic [33:0] act;
      act = {a_o, x_o, y_o, a_we_o, x_we_o, y_we_o, n_o, v_o, z_o, c_o};
      if (done_o) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R2: done without strobe, actual done=1 expected done=0");
        end else begin
          exp_t e;
          e = q.pop_front();
          if (act !== e.bits) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", e.req, act, e.bits);
          end
        end
      end else begin
        checks++;
        if ((a_we_o | x_we_o | y_we_o) !== 1'b0 || q.size() > 0 && !exec_i && q.size() > 0 && 0) begin
          errors++;
          $display("FAIL R2: idle enables actual %b%b%b expected 000", a_we_o, x_we_o, y_we_o);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({done_o, a_we_o, x_we_o, y_we_o, a_o, x_o, y_o, n_o, v_o, z_o, c_o} !== '0) begin
      errors++;
      $display("FAIL R1: reset outputs actual %h expected 0",
               {done_o, a_we_o, x_we_o, y_we_o, a_o, x_o, y_o, n_o, v_o, z_o, c_o});
    end
    rst_n = 1'b1;
    running = 1;
    idle(2);
    // R3 flag ops, R4 copies, R5 swaps across flag patterns
    for (int fl = 0; fl < 16; fl += 5) begin
      for (int op = 0; op <= 6; op++) issue(op, 8'h80, 8'h00, 8'h7F, fl);
    end
    issue(2, 8'h12, 8'h00, 8'h55, 4'b1000);   // R4 copy of zero sets Z
    issue(6, 8'h12, 8'h90, 8'h00, 4'b0000);   // R5 X gets zero
    idle(1);
    // R6 logic
    for (int op = 7; op <= 12; op++) begin
      issue(op, 8'hF0, 8'h0F, 8'hCC, 4'b0101);
      issue(op, 8'h00, 8'h00, 8'h00, 4'b1010);
      issue(op, 8'hAA, 8'hFF, 8'h55, 4'b0000);
    end
    idle(3);
    // R7 add: plain, signed overflow, carry out, zero result
    issue(13, 8'h10, 8'h20, 8'h00, 4'b0000);
    issue(13, 8'h7F, 8'h01, 8'h00, 4'b0000);
    issue(14, 8'hFF, 8'h00, 8'h01, 4'b0000);
    issue(14, 8'hFF, 8'h00, 8'h00, 4'b0001);
    issue(13, 8'h80, 8'h80, 8'h00, 4'b0000);
    // R8 subtract: no borrow, borrow, overflow, incoming borrow
    issue(15, 8'h50, 8'h20, 8'h00, 4'b0001);
    issue(15, 8'h20, 8'h50, 8'h00, 4'b0001);
    issue(16, 8'h80, 8'h00, 8'h01, 4'b0001);
    issue(16, 8'h05, 8'h00, 8'h05, 4'b0000);
    issue(15, 8'h7F, 8'hFF, 8'h00, 4'b0001);
    idle(1);
    // R9 compares: all six, greater/equal/less
    for (int op = 17; op <= 22; op++) begin
      issue(op, 8'h40, 8'h40, 8'h40, 4'b0100);
      issue(op, 8'h01, 8'hFF, 8'h80, 4'b0000);
      issue(op, 8'hFE, 8'h02, 8'h7F, 4'b1111);
    end
    // R10 reserved codes
    for (int op = 23; op <= 31; op++) issue(op, 8'h00, 8'h11, 8'hEE, op % 16);
    // sweep every code over a few patterns, with gaps (R2)
    for (int k = 0; k < 4; k++) begin
      for (int op = 0; op < 32; op++) begin
        issue(op, (37 * k + 5 * op) % 256, (91 * k + 13) % 256, (200 - 7 * op) % 256, (k + op) % 16);
        if (op % 7 == 0) idle(1);
      end
    end
    idle(4);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2: pending results actual %0d expected 0", q.size());
    end
    running = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule